// File: doc/BRIEF.md
# Legacy Paging Register Alias Unit

This block holds the classic paging state that three legacy I/O ports normally set. The bank port holds a 3-bit RAM bank and a ROM select bit. The extended-bank port holds the fourth RAM bank bit. The special-mode port holds the paging mode and two configuration bits. The block also offers a single combined control register, the alias, on an indexed register interface. Software can read the whole paging state, or change it, in one access instead of three port writes.

From the held state the block drives the ROM select, the allRAM enable and configuration, and the page numbers of the two upper 8K MMU slots. The upper slots always hold the even and odd halves of the current 16K RAM bank. A write through the alias lands in the same port fields a port write would use, so the two paths stay in step. Register writes that come from the co-processor path are ignored at the alias index, because that index lies above the co-processor's reachable range.

Top module: `legacy_page_alias`

## Requirements
- R1: After reset, the RAM bank is 0, paging mode is normal (`allram_en`=0), `rom_sel`=0, `allram_cfg`=0, `mmu_slot6`=0 and `mmu_slot7`=1.
- R2: A read of the alias index (`reg_idx`=`ALIAS_IDX`) returns {ext bit0, bank bits2:0, 1, mode, mode-port bit2, X} on bits 7..0. Bit 3 is always 1. X is mode-port bit1 when the mode is special and bank-port bit4 when it is normal. Any other index reads 0.
- R3: An accepted alias write with data bit 3 = 1 sets the RAM bank to {data[7], data[6:4]}. On the clock after the state update, `mmu_slot6` becomes bank*2 and `mmu_slot7` becomes bank*2+1.
- R4: An accepted alias write with data bit 3 = 0 leaves the RAM bank, `mmu_slot6` and `mmu_slot7` unchanged.
- R5: Every accepted alias write copies data bit 2 to the paging mode and data bit 1 to mode-port bit 2. When data bit 2 = 0 (normal mode), data bit 0 goes to bank-port bit 4 and mode-port bit 1 is kept.
- R6: When an accepted alias write has data bit 2 = 1 (special allRAM mode), data bit 0 goes to mode-port bit 1 and bank-port bit 4 is kept.
- R7: A register write is ignored if `reg_idx` differs from `ALIAS_IDX`, or if `reg_copro`=1 and the index is above `COPRO_MAX_IDX`.
- R8: A bank-port write loads bank bits 2:0 from data[2:0] and ROM bit from data[4]. An extended-bank write loads bank bit 3 from data[0]. A mode-port write loads the mode, mode bit1 and mode bit2 from data[0], data[1] and data[2]. Each touches only its own fields, and a bank change moves the MMU slots as in R3.
- R9: `rom_sel` = {mode-port bit2, bank-port bit4}, `allram_cfg` = {mode-port bit2, mode-port bit1} and `allram_en` = mode, all valid one clock after the write.
- R10: When an alias write and a port write arrive in the same cycle, the alias write wins on every field it writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_port_wr | input | 1 | Write strobe for the bank port |
| ext_port_wr | input | 1 | Write strobe for the extended-bank port |
| mode_port_wr | input | 1 | Write strobe for the special-mode port |
| port_wdata | input | 8 | Data for port writes |
| reg_wr | input | 1 | Register write strobe |
| reg_copro | input | 1 | Register access comes from the co-processor |
| reg_idx | input | IDX_W | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ram_bank | output | 4 | Current 16K RAM bank |
| rom_sel | output | 2 | ROM select |
| allram_en | output | 1 | Special allRAM mode active |
| allram_cfg | output | 2 | allRAM configuration |
| mmu_slot6 | output | PAGE_W | 8K page in MMU slot 6 |
| mmu_slot7 | output | PAGE_W | 8K page in MMU slot 7 |

## Verification
The assertions on alias writes assume that no port write strobes in the same cycle. Under that assumption a field the alias leaves alone cannot move. The stimulus fires one strobe per operation with an idle cycle after it, except in one directed collision case that exercises R10. The random index is drawn around the alias index, so accepted, foreign-index and co-processor-blocked writes all occur.

// File: rtl/lpa_pkg.sv
package lpa_pkg;

  // Paging state, held as the legacy port fields.
  typedef struct packed {
    logic       ext_b0;    // extended-bank port bit 0
    logic [2:0] bank_lo;   // bank port bits 2:0
    logic       bank_rom;  // bank port bit 4
    logic       mode_en;   // special-mode port bit 0
    logic       mode_b1;   // special-mode port bit 1
    logic       mode_b2;   // special-mode port bit 2
  } page_state_t;

  function automatic logic [3:0] bank_of(page_state_t s);
    return {s.ext_b0, s.bank_lo};
  endfunction

  function automatic logic [7:0] alias_encode(page_state_t s);
    logic low;
    low = s.mode_en ? s.mode_b1 : s.bank_rom;
    return {s.ext_b0, s.bank_lo, 1'b1, s.mode_en, s.mode_b2, low};
  endfunction

  // Apply an alias write to a state value.
  function automatic page_state_t alias_apply(page_state_t s, logic [7:0] d);
    page_state_t n;
    n = s;
    if (d[3]) begin
      n.ext_b0  = d[7];
      n.bank_lo = d[6:4];
    end
    n.mode_en = d[2];
    n.mode_b2 = d[1];
    if (d[2]) n.mode_b1  = d[0];
    else      n.bank_rom = d[0];
    return n;
  endfunction

endpackage

// File: rtl/lpa_alias_codec.sv
module lpa_alias_codec
  import lpa_pkg::*;
#(
  parameter int IDX_W         = 8,
  parameter int ALIAS_IDX     = 8'h8E,
  parameter int COPRO_MAX_IDX = 8'h7F
) (
  input  logic             reg_wr,
  input  logic             reg_copro,
  input  logic [IDX_W-1:0] reg_idx,
  input  page_state_t      st,
  output logic             alias_acc,
  output logic [7:0]       rdata
);
  localparam logic [IDX_W-1:0] IDX_HIT = IDX_W'(ALIAS_IDX);
  localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(COPRO_MAX_IDX);

  logic hit;
  logic copro_block;

  always_comb begin
    hit         = (reg_idx == IDX_HIT);
    copro_block = reg_copro && (reg_idx > IDX_LIM);
    alias_acc   = reg_wr && hit && !copro_block;
    rdata       = hit ? alias_encode(st) : 8'h00;
  end
endmodule

// File: rtl/lpa_port_regs.sv
module lpa_port_regs
  import lpa_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bank_port_wr,
  input  logic        ext_port_wr,
  input  logic        mode_port_wr,
  input  logic [7:0]  port_wdata,
  input  logic        alias_acc,
  input  logic [7:0]  alias_wdata,
  output page_state_t st,
  output logic        bank_upd
);
  page_state_t nxt;

  always_comb begin
    nxt = st;
    if (bank_port_wr) begin
      nxt.bank_lo  = port_wdata[2:0];
      nxt.bank_rom = port_wdata[4];
    end
    if (ext_port_wr) nxt.ext_b0 = port_wdata[0];
    if (mode_port_wr) begin
      nxt.mode_en = port_wdata[0];
      nxt.mode_b1 = port_wdata[1];
      nxt.mode_b2 = port_wdata[2];
    end
    if (alias_acc) nxt = alias_apply(nxt, alias_wdata);
  end

  assign bank_upd = bank_port_wr | ext_port_wr | (alias_acc & alias_wdata[3]);

  always_ff @(posedge clk) begin
    if (!rst_n) st <= '0;
    else        st <= nxt;
  end
endmodule

// File: rtl/lpa_mmu_upper.sv
module lpa_mmu_upper #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_upd,
  input  logic [3:0]        bank,
  output logic              mmu_load,
  output logic [PAGE_W-1:0] slot6,
  output logic [PAGE_W-1:0] slot7
);
  function automatic logic [PAGE_W-1:0] page_even(logic [3:0] b);
    return PAGE_W'({b, 1'b0});
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mmu_load <= 1'b0;
      slot6    <= '0;
      slot7    <= PAGE_W'(1);
    end else begin
      mmu_load <= bank_upd;
      if (mmu_load) begin
        slot6 <= page_even(bank);
        slot7 <= page_even(bank) | PAGE_W'(1);
      end
    end
  end
endmodule

// File: rtl/legacy_page_alias.sv
module legacy_page_alias
  import lpa_pkg::*;
#(
  parameter int IDX_W         = 8,
  parameter int PAGE_W        = 8,
  parameter int ALIAS_IDX     = 8'h8E,
  parameter int COPRO_MAX_IDX = 8'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_port_wr,
  input  logic              ext_port_wr,
  input  logic              mode_port_wr,
  input  logic [7:0]        port_wdata,
  input  logic              reg_wr,
  input  logic              reg_copro,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [3:0]        ram_bank,
  output logic [1:0]        rom_sel,
  output logic              allram_en,
  output logic [1:0]        allram_cfg,
  output logic [PAGE_W-1:0] mmu_slot6,
  output logic [PAGE_W-1:0] mmu_slot7
);
  page_state_t st;
  logic        alias_acc;
  logic        bank_upd;
  logic        mmu_load;

  lpa_alias_codec #(
    .IDX_W(IDX_W), .ALIAS_IDX(ALIAS_IDX), .COPRO_MAX_IDX(COPRO_MAX_IDX)
  ) u_codec (
    .reg_wr(reg_wr), .reg_copro(reg_copro), .reg_idx(reg_idx),
    .st(st), .alias_acc(alias_acc), .rdata(reg_rdata)
  );

  lpa_port_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bank_port_wr(bank_port_wr), .ext_port_wr(ext_port_wr),
    .mode_port_wr(mode_port_wr), .port_wdata(port_wdata),
    .alias_acc(alias_acc), .alias_wdata(reg_wdata),
    .st(st), .bank_upd(bank_upd)
  );

  lpa_mmu_upper #(.PAGE_W(PAGE_W)) u_mmu (
    .clk(clk), .rst_n(rst_n), .bank_upd(bank_upd), .bank(ram_bank),
    .mmu_load(mmu_load), .slot6(mmu_slot6), .slot7(mmu_slot7)
  );

  always_comb begin
    ram_bank   = bank_of(st);
    rom_sel    = {st.mode_b2, st.bank_rom};
    allram_en  = st.mode_en;
    allram_cfg = {st.mode_b2, st.mode_b1};
  end
endmodule

// File: rtl/lpa_checker.sv
module lpa_checker #(
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bank_port_wr,
  input logic              ext_port_wr,
  input logic              mode_port_wr,
  input logic              reg_wr,
  input logic              reg_copro,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic [3:0]        ram_bank,
  input logic              allram_en,
  input logic [1:0]        allram_cfg,
  input logic [1:0]        rom_sel,
  input logic [PAGE_W-1:0] mmu_slot6,
  input logic [PAGE_W-1:0] mmu_slot7,
  input logic              alias_acc,
  input logic              bank_upd,
  input logic              mmu_load
);
  logic no_port;
  assign no_port = !bank_port_wr && !ext_port_wr && !mode_port_wr;

  AST_RESET_PAGES: assert property (@(posedge clk) !rst_n |=> (mmu_slot6 == '0 && mmu_slot7 == PAGE_W'(1))); // R1
  AST_READ_BIT3: assert property (@(posedge clk) disable iff (!rst_n) (reg_rdata != 8'h00) |-> reg_rdata[3]); // R2
  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (alias_acc && reg_wdata[3] && no_port) |=> (ram_bank == {$past(reg_wdata[7]), $past(reg_wdata[6:4])})); // R3
  AST_MMU_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) bank_upd |=> mmu_load); // R3
  AST_MMU_PAGES: assert property (@(posedge clk) disable iff (!rst_n) mmu_load |=> (mmu_slot6 == PAGE_W'({$past(ram_bank), 1'b0}) && mmu_slot7 == PAGE_W'({$past(ram_bank), 1'b1}))); // R3
  AST_BANK_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (alias_acc && !reg_wdata[3] && no_port) |=> $stable(ram_bank)); // R4
  AST_MODE_SET: assert property (@(posedge clk) disable iff (!rst_n) alias_acc |=> (allram_en == $past(reg_wdata[2]))); // R5
  AST_CFG_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n) (alias_acc && reg_wdata[2]) |=> (allram_cfg == $past(reg_wdata[1:0]))); // R6
  AST_COPRO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && reg_copro && no_port) |=> ($stable(ram_bank) && $stable(rom_sel) && $stable(allram_cfg) && $stable(allram_en))); // R7
endmodule

bind legacy_page_alias lpa_checker #(.PAGE_W(PAGE_W)) u_lpa_checker (
  .clk(clk), .rst_n(rst_n),
  .bank_port_wr(bank_port_wr), .ext_port_wr(ext_port_wr), .mode_port_wr(mode_port_wr),
  .reg_wr(reg_wr), .reg_copro(reg_copro), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .ram_bank(ram_bank), .allram_en(allram_en), .allram_cfg(allram_cfg), .rom_sel(rom_sel),
  .mmu_slot6(mmu_slot6), .mmu_slot7(mmu_slot7),
  .alias_acc(alias_acc), .bank_upd(bank_upd), .mmu_load(mmu_load)
);

// File: tb/test_legacy_page_alias.sv
`timescale 1ns/1ps
module test_legacy_page_alias;
  localparam int IDX_W = 8;
  localparam int PAGE_W = 8;
  localparam logic [7:0] AIDX = 8'h8E;

  logic clk = 1'b0;
  logic rst_n;
  logic bank_port_wr, ext_port_wr, mode_port_wr;
  logic [7:0] port_wdata;
  logic reg_wr, reg_copro;
  logic [IDX_W-1:0] reg_idx;
  logic [7:0] reg_wdata, reg_rdata;
  logic [3:0] ram_bank;
  logic [1:0] rom_sel, allram_cfg;
  logic allram_en;
  logic [PAGE_W-1:0] mmu_slot6, mmu_slot7;

  always #2.5 clk = ~clk;

  legacy_page_alias i_legacy_page_alias (
    .clk(clk), .rst_n(rst_n),
    .bank_port_wr(bank_port_wr), .ext_port_wr(ext_port_wr), .mode_port_wr(mode_port_wr),
    .port_wdata(port_wdata), .reg_wr(reg_wr), .reg_copro(reg_copro), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ram_bank(ram_bank), .rom_sel(rom_sel),
    .allram_en(allram_en), .allram_cfg(allram_cfg), .mmu_slot6(mmu_slot6), .mmu_slot7(mmu_slot7)
  );

  // Reference model, kept as named port fields.
  logic m_ext, m_rom, m_mode, m_c1, m_c2;
  logic [2:0] m_lo;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [7:0] exp_read();
    logic [7:0] r;
    r[7] = m_ext; r[6:4] = m_lo; r[3] = 1'b1; r[2] = m_mode; r[1] = m_c2;
    r[0] = m_mode ? m_c1 : m_rom;
    return r;
  endfunction

  function automatic logic [3:0] exp_bank();
    return {m_ext, m_lo};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    reg_idx = AIDX;
    #0.1;
    check({tag, " read"}, 32'(reg_rdata), 32'(exp_read()));
    check({tag, " bank"}, 32'(ram_bank), 32'(exp_bank()));
    check({tag, " R9 rom"}, 32'(rom_sel), 32'({m_c2, m_rom}));
    check({tag, " R9 cfg"}, 32'({allram_en, allram_cfg}), 32'({m_mode, m_c2, m_c1}));
    check({tag, " slot6"}, 32'(mmu_slot6), 32'(exp_bank()) * 2);
    check({tag, " slot7"}, 32'(mmu_slot7), 32'(exp_bank()) * 2 + 1);
  endtask

  task automatic idle_all();
    bank_port_wr = 0; ext_port_wr = 0; mode_port_wr = 0; reg_wr = 0; reg_copro = 0;
  endtask

  // One strobe cycle, then one idle cycle so the MMU slots settle.
  task automatic finish_op();
    @(negedge clk); idle_all();
    @(negedge clk);
  endtask

  task automatic model_alias(logic [7:0] d);
    if (d[3]) begin m_ext = d[7]; m_lo = d[6:4]; end
    m_mode = d[2]; m_c2 = d[1];
    if (d[2]) m_c1 = d[0]; else m_rom = d[0];
  endtask

  task automatic do_reg(logic [7:0] idx, logic copro, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_copro = copro; reg_idx = idx; reg_wdata = d;
    if (idx == AIDX && !(copro && idx > 8'h7F)) model_alias(d);
    finish_op();
  endtask

  task automatic do_port(int which, logic [7:0] d);
    @(negedge clk);
    port_wdata = d;
    case (which)
      0: begin bank_port_wr = 1; m_lo = d[2:0]; m_rom = d[4]; end
      1: begin ext_port_wr = 1; m_ext = d[0]; end
      default: begin mode_port_wr = 1; m_mode = d[0]; m_c1 = d[1]; m_c2 = d[2]; end
    endcase
    finish_op();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5A17;
    void'($urandom(seed));
    idle_all(); port_wdata = 0; reg_idx = AIDX; reg_wdata = 0;
    m_ext = 0; m_lo = 0; m_rom = 0; m_mode = 0; m_c1 = 0; m_c2 = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");
    check("R2 bit3 set", 32'(reg_rdata[3]), 1);
    reg_idx = 8'h10; #0.1;
    check("R2 other index reads zero", 32'(reg_rdata), 0);

    do_reg(AIDX, 0, 8'hF8); check_all("R3 bank 15");
    do_reg(AIDX, 0, 8'h50); check_all("R4 bit3 clear keeps bank");
    do_reg(AIDX, 0, 8'h07); check_all("R6 special cfg");
    do_reg(AIDX, 0, 8'h18); check_all("R5 normal keeps cfg bit");
    do_reg(AIDX, 0, 8'h05); check_all("R6 special keeps rom bit");
    do_reg(AIDX, 1, 8'h28); check_all("R7 copro ignored");
    do_reg(8'h8D, 0, 8'h28); check_all("R7 other index ignored");
    do_port(0, 8'h13); check_all("R8 bank port");
    do_port(1, 8'h01); check_all("R8 ext port");
    do_port(2, 8'h06); check_all("R8 mode port");

    // R10: alias write and bank port write together; alias wins on bank bits.
    @(negedge clk);
    bank_port_wr = 1; port_wdata = 8'h15;
    reg_wr = 1; reg_copro = 0; reg_idx = AIDX; reg_wdata = 8'h2A;
    m_lo = 3'd5; m_rom = 1'b1;
    model_alias(8'h2A);
    finish_op();
    check_all("R10 alias wins");

    for (int i = 0; i < 300; i++) begin
      int kind;
      logic [7:0] d, idx;
      kind = int'($urandom_range(0, 4));
      d = 8'($urandom);
      if (kind < 3) begin
        idx = ($urandom_range(0, 3) == 0) ? 8'($urandom) : AIDX;
        do_reg(idx, 1'($urandom_range(0, 3) == 0), d);
        check_all("R3 R4 R5 R6 R7 random reg");
      end else begin
        do_port(int'($urandom_range(0, 2)), d);
        check_all("R8 random port");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule